// File: doc/BRIEF.md
# Infrared Pulse Timing Capture Receiver

This block measures the symbols of a demodulated remote-control signal. The input pin is first resynchronised and can be inverted. It is then sampled on a tick made by a programmable divider of the system clock. For every symbol the block counts two values in sample ticks. The mark is how long the input stays asserted. The period runs from the start of that mark to the start of the next one. Each pair of counts enters an eight-entry FIFO.

When the space after a mark grows until the period count reaches a programmable limit, the symbol is closed with the reserved period code 0xFFFF. This tells software that the pulse train has ended, and the block then waits idle for the next asserted sample. Software drains the FIFO through a small register port. It reads the period of the head entry first; reading the mark of that entry then removes it. Four interrupt flags, each gated by a mask bit, report stored data, the end of a train, a dropped entry and the FIFO turning full.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset the interrupt flags, mask, FIFO level and overflow bit read 0, and `irq` is low.
- R2: A symbol is stored as a mark count, equal to the number of asserted samples, and a period count, equal to the samples from its first asserted sample to the first asserted sample of the next symbol.
- R3: When the space after a mark lets the period count reach the LIMIT register (offset 0x08), the entry is stored with period 0xFFFF; the next symbol starts counting at the next asserted sample.
- R4: The PRESCALE register (offset 0x04) set to N ≥ 2 takes one sample every N clocks; 0 or 1 samples on every clock.
- R5: CTRL bit 1 (offset 0x00) inverts the input, so a low pin counts as a mark.
- R6: While CTRL bit 0 (run) is 0, no entry is stored and any partly measured symbol is dropped.
- R7: The FIFO keeps 8 entries. A symbol that completes while it is full is discarded, and the older entries stay. The discard sets STATUS bit 2 (offset 0x18).
- R8: FLAGS (offset 0x10) bit 0 latches on each stored entry, bit 1 on a stored timeout entry, bit 2 on a discard, and bit 3 when the FIFO becomes full. Each bit latches only when the matching MASK bit (offset 0x0C) is 1. `irq` is the OR of FLAGS.
- R9: Writing 1 to a bit of ACK (offset 0x14) clears that FLAGS bit; writing 1 to bit 2 also clears STATUS bit 2.
- R10: Mark and period counts saturate at 0xFFFE.
- R11: PERIOD (offset 0x1C) shows the head period. Reading MARK (offset 0x20) returns the head mark and removes the entry. Reads of an empty FIFO return 0 and change nothing. STATUS bits 15:8 hold the FIFO level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver pin, asynchronous |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe for one cycle (MARK read removes the entry) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the latched interrupt flags |

## Verification
A corrupted meter state shows up as a wrong mark or period in the next pair that is read. A meter stuck out of idle shows up as an entry stored after a train has ended. Both become visible when the next symbol closes, within one limit interval. A wrong FIFO pointer or level appears at once in STATUS bits 15:8, or in the order of the pairs read back. A wrong flag, mask or acknowledge path shows on `irq` in the cycle after the event or the write.

// File: rtl/ir_rx_pkg.sv
// Shared constants and types of the infrared capture receiver.
// Assumes 16-bit measurements and byte register offsets on an 8-bit address.
package ir_rx_pkg;
    localparam int MEAS_W = 16;
    localparam logic [MEAS_W-1:0] CODE_TIMEOUT = '1;
    localparam logic [MEAS_W-1:0] CODE_SAT     = {{(MEAS_W-1){1'b1}}, 1'b0};

    localparam logic [7:0] ADR_CTRL   = 8'h00;
    localparam logic [7:0] ADR_PRESC  = 8'h04;
    localparam logic [7:0] ADR_LIMIT  = 8'h08;
    localparam logic [7:0] ADR_MASK   = 8'h0C;
    localparam logic [7:0] ADR_FLAGS  = 8'h10;
    localparam logic [7:0] ADR_ACK    = 8'h14;
    localparam logic [7:0] ADR_STATUS = 8'h18;
    localparam logic [7:0] ADR_PERIOD = 8'h1C;
    localparam logic [7:0] ADR_MARK   = 8'h20;

    localparam int IRQ_N    = 4;
    localparam int IRQ_DATA = 0;
    localparam int IRQ_LAST = 1;
    localparam int IRQ_OVR  = 2;
    localparam int IRQ_FULL = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} meter_state_t;

    typedef struct packed {
        logic [MEAS_W-1:0] mark;
        logic [MEAS_W-1:0] period;
    } meas_t;
endpackage

// File: rtl/ir_tick_gen.sv
// Sample tick divider: one tick every DIV clocks, every clock when DIV < 2.
// Assumes DIV may change at any time; the counter resynchronises on the next tick.
module ir_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (div < DIV_W'(2)) || (cnt >= div - DIV_W'(1));

    // Count clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/ir_symbol_meter.sv
// Measures mark and period of each symbol on sample ticks and emits one
// registered result per symbol, or a timeout result when the space reaches
// the limit. Assumes 'level' is already synchronised and polarity corrected.
module ir_symbol_meter
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              level,
    input  logic [MEAS_W-1:0] limit,
    output logic              emit,
    output meas_t             emit_meas
);
    meter_state_t      state;
    logic [MEAS_W-1:0] mark_cnt, per_cnt, mark_inc, per_inc;

    assign mark_inc = (mark_cnt == CODE_SAT) ? CODE_SAT : mark_cnt + MEAS_W'(1);
    assign per_inc  = (per_cnt  == CODE_SAT) ? CODE_SAT : per_cnt  + MEAS_W'(1);

    // Symbol state machine and saturating counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mark_cnt  <= '0;
            per_cnt   <= '0;
            emit      <= 1'b0;
            emit_meas <= '0;
        end else begin
            emit <= 1'b0;
            if (!run) begin
                state <= ST_IDLE;
            end else if (tick) begin
                case (state)
                    ST_IDLE: if (level) begin
                        mark_cnt <= MEAS_W'(1);
                        per_cnt  <= MEAS_W'(1);
                        state    <= ST_MARK;
                    end
                    ST_MARK: begin
                        per_cnt <= per_inc;
                        if (level) mark_cnt <= mark_inc;
                        else       state    <= ST_SPACE;
                    end
                    ST_SPACE: begin
                        if (level) begin
                            emit      <= 1'b1;
                            emit_meas <= '{mark: mark_cnt, period: per_cnt};
                            mark_cnt  <= MEAS_W'(1);
                            per_cnt   <= MEAS_W'(1);
                            state     <= ST_MARK;
                        end else if (per_inc >= limit) begin
                            emit      <= 1'b1;
                            emit_meas <= '{mark: mark_cnt, period: CODE_TIMEOUT};
                            state     <= ST_IDLE;
                        end else begin
                            per_cnt <= per_inc;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: a measured mark never takes the reserved code
    a_r10_mark_below_code: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (emit_meas.mark != CODE_TIMEOUT));
    // R6: no result follows a cycle with run low
    a_r6_no_emit_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !emit);
endmodule

// File: rtl/ir_pair_fifo.sv
// Measurement FIFO of DEPTH entries. A push into a full FIFO is discarded
// and flagged on 'drop'. Reading an empty FIFO shows zero and pops nothing.
module ir_pair_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop, empty;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and level bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7: level never exceeds the depth
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7: a discarded push leaves a full FIFO full
    a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> full);
    // R11: a read of an empty FIFO changes nothing
    a_r11_empty_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ir_capture_rx.sv
// Infrared capture receiver top: input synchroniser and inversion, sample
// divider, symbol meter, measurement FIFO, registers and interrupt flags.
// Assumes single-cycle bus strobes and a combinational read path.
module ir_capture_rx
    import ir_rx_pkg::*;
#(
    parameter int          FIFO_DEPTH = 8,
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 32,
    parameter int          PRESC_W    = 16,
    parameter logic [15:0] LIMIT_RST  = 16'd20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CW     = $clog2(FIFO_DEPTH + 1);
    localparam int MEAS2W = 2 * MEAS_W;

    logic               run_q, inv_q, ovf_q, full_q;
    logic [PRESC_W-1:0] presc_q;
    logic [MEAS_W-1:0]  limit_q;
    logic [IRQ_N-1:0]   mask_q, flags_q, evt, ack;
    logic [1:0]         sync_q;
    logic               level, tick, emit, f_full, f_drop, f_pop, stored;
    meas_t              emit_meas, head;
    logic [MEAS2W-1:0]  head_raw;
    logic [CW-1:0]      f_count;

    // Two-flop synchroniser on the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], ir_in};
    end
    assign level = sync_q[1] ^ inv_q;

    ir_tick_gen #(.DIV_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(presc_q), .tick(tick));

    ir_symbol_meter u_meter (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .level(level),
        .limit(limit_q), .emit(emit), .emit_meas(emit_meas));

    assign f_pop = bus_rd && (bus_addr == ADDR_W'(ADR_MARK));

    ir_pair_fifo #(.DEPTH(FIFO_DEPTH), .DW(MEAS2W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(emit), .din(emit_meas), .pop(f_pop),
        .dout(head_raw), .count(f_count), .full(f_full), .drop(f_drop));
    assign head = meas_t'(head_raw);

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            inv_q   <= 1'b0;
            presc_q <= PRESC_W'(1);
            limit_q <= LIMIT_RST;
            mask_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(ADR_CTRL):  begin run_q <= bus_wdata[0]; inv_q <= bus_wdata[1]; end
                ADDR_W'(ADR_PRESC): presc_q <= bus_wdata[PRESC_W-1:0];
                ADDR_W'(ADR_LIMIT): limit_q <= bus_wdata[MEAS_W-1:0];
                ADDR_W'(ADR_MASK):  mask_q  <= bus_wdata[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    // Raw interrupt events and acknowledge strobe.
    always_comb begin
        stored        = emit && !f_full;
        evt           = '0;
        evt[IRQ_DATA] = stored;
        evt[IRQ_LAST] = stored && (emit_meas.period == CODE_TIMEOUT);
        evt[IRQ_OVR]  = f_drop;
        evt[IRQ_FULL] = f_full && !full_q;
        ack = (bus_wr && bus_addr == ADDR_W'(ADR_ACK)) ? bus_wdata[IRQ_N-1:0] : '0;
    end

    // Latched flags, sticky overflow and full-edge tracker; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ovf_q   <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~ack) | (evt & mask_q);
            ovf_q   <= f_drop | (ovf_q & ~ack[IRQ_OVR]);
            full_q  <= f_full;
        end
    end

    assign irq = |flags_q;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_CTRL):   bus_rdata = DATA_W'({inv_q, run_q});
            ADDR_W'(ADR_PRESC):  bus_rdata = DATA_W'(presc_q);
            ADDR_W'(ADR_LIMIT):  bus_rdata = DATA_W'(limit_q);
            ADDR_W'(ADR_MASK):   bus_rdata = DATA_W'(mask_q);
            ADDR_W'(ADR_FLAGS):  bus_rdata = DATA_W'(flags_q);
            ADDR_W'(ADR_STATUS): bus_rdata = DATA_W'({8'(f_count), 5'b0, ovf_q, 2'b0});
            ADDR_W'(ADR_PERIOD): bus_rdata = DATA_W'(head.period);
            ADDR_W'(ADR_MARK):   bus_rdata = DATA_W'(head.mark);
            default:             bus_rdata = '0;
        endcase
    end

    // R8: the data flag only rises when its mask bit was set
    a_r8_data_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[IRQ_DATA]) |-> $past(mask_q[IRQ_DATA]));
    // R8: the overrun flag only rises when its mask bit was set
    a_r8_ovr_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[IRQ_OVR]) |-> $past(mask_q[IRQ_OVR]));
    // R9: an acknowledge with no new event clears the data flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[IRQ_DATA] && !stored) |=> !flags_q[IRQ_DATA]);
    // R7: a discard leaves the overflow bit set
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        f_drop |=> ovf_q);
endmodule

// File: tb/ir_capture_rx_bench.sv
// Directed bench for the infrared capture receiver.
module ir_capture_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_PRESC = 8'h04, A_LIMIT = 8'h08,
        A_MASK = 8'h0C, A_FLAGS = 8'h10, A_ACK = 8'h14, A_STATUS = 8'h18,
        A_PERIOD = 8'h1C, A_MARK = 8'h20;

    ir_capture_rx u_ir_capture_rx (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic hold(input logic v, input int n);
        @(negedge clk);
        ir_in = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic expect_pair(input string req, input logic [15:0] m, input logic [15:0] p);
        logic [31:0] d;
        rd(A_PERIOD, d); chk({req, " period"}, d, {16'h0, p});
        rd(A_MARK, d);   chk({req, " mark"}, d, {16'h0, m});
    endtask

    task automatic expect_level(input string req, input int n);
        logic [31:0] d;
        rd(A_STATUS, d); chk({req, " level"}, {24'h0, d[15:8]}, n);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_FLAGS, d);  chk("R1 flags", d, 0);
        rd(A_MASK, d);   chk("R1 mask", d, 0);
        rd(A_STATUS, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_pairs;
        logic [31:0] d;
        wr(A_LIMIT, 1000); wr(A_MASK, 4'hF); wr(A_CTRL, 1);
        hold(1, 5); hold(0, 7); hold(1, 4); hold(0, 9); hold(1, 2); hold(0, 1100);
        expect_level("R11", 3);
        rd(A_FLAGS, d); chk("R8 flags data+last", d, 32'h3);
        chk("R8 irq", {31'b0, irq}, 1);
        expect_pair("R2 first", 5, 12);
        expect_pair("R2 second", 4, 13);
        expect_pair("R3 timeout", 2, 16'hFFFF);
        expect_level("R11 drained", 0);
        rd(A_MARK, d); chk("R11 empty mark", d, 0);
        expect_level("R11 empty unchanged", 0);
        wr(A_ACK, 4'hF);
        rd(A_FLAGS, d); chk("R9 cleared", d, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_gating;
        logic [31:0] d;
        wr(A_MASK, 0);
        hold(1, 3); hold(0, 4); hold(1, 3); hold(0, 1100);
        rd(A_FLAGS, d); chk("R8 masked flags", d, 0);
        chk("R8 masked irq", {31'b0, irq}, 0);
        expect_level("R8 masked stored", 2);
        expect_pair("R2 gated", 3, 7);
        expect_pair("R3 restart timeout", 3, 16'hFFFF);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        wr(A_MASK, 4'hF);
        hold(1, 10);
        wr(A_CTRL, 0);
        hold(0, 5); hold(1, 6); hold(0, 6); hold(1, 3); hold(0, 1100);
        expect_level("R6 stopped", 0);
        rd(A_FLAGS, d); chk("R6 no flags", d, 0);
        wr(A_CTRL, 1);
        hold(1, 4); hold(0, 4); hold(1, 2); hold(0, 1100);
        expect_pair("R6 restart", 4, 8);
        expect_pair("R6 restart timeout", 2, 16'hFFFF);
        wr(A_ACK, 4'hF);
    endtask

    task automatic t_prescale;
        wr(A_PRESC, 4); wr(A_LIMIT, 50);
        hold(1, 12); hold(0, 20); hold(1, 8); hold(0, 300);
        expect_pair("R4 divided", 3, 8);
        expect_pair("R4 divided timeout", 2, 16'hFFFF);
        wr(A_PRESC, 1); wr(A_LIMIT, 1000);
    endtask

    task automatic t_invert;
        wr(A_CTRL, 2);
        hold(1, 5);
        wr(A_CTRL, 3);
        hold(0, 6); hold(1, 4); hold(0, 5); hold(1, 1100);
        expect_pair("R5 inverted", 6, 10);
        expect_pair("R5 inverted timeout", 5, 16'hFFFF);
        wr(A_CTRL, 0);
        hold(0, 5);
        wr(A_CTRL, 1);
        wr(A_ACK, 4'hF);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        for (int i = 0; i < 10; i++) begin
            hold(1, i + 1); hold(0, 3);
        end
        hold(0, 1100);
        expect_level("R7 full", 8);
        rd(A_STATUS, d); chk("R7 overflow bit", {31'b0, d[2]}, 1);
        rd(A_FLAGS, d);  chk("R8 flags data+ovr+full", d, 32'hD);
        wr(A_ACK, 4'h4);
        rd(A_STATUS, d); chk("R9 overflow cleared", {31'b0, d[2]}, 0);
        rd(A_FLAGS, d);  chk("R9 partial ack", d, 32'h9);
        for (int i = 0; i < 8; i++) begin
            expect_pair("R7 kept order", 16'(i + 1), 16'(i + 4));
        end
        rd(A_PERIOD, d); chk("R11 empty period", d, 0);
        expect_level("R7 drained", 0);
        wr(A_ACK, 4'hF);
    endtask

    task automatic t_saturate;
        wr(A_LIMIT, 32'hFFFF); wr(A_MASK, 0);
        hold(1, 70000); hold(0, 10); hold(1, 3); hold(0, 5);
        expect_level("R10 stored", 1);
        expect_pair("R10 saturated", 16'hFFFE, 16'hFFFE);
        wr(A_CTRL, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pairs();
        t_gating();
        t_disable();
        t_prescale();
        t_invert();
        t_overflow();
        t_saturate();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule